// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block is the external bus engine of a small processor core that shares one set of pins between the low address bits and the data byte. The core places a request on an internal port. The request carries a 20-bit address, the transfer direction, a memory or I/O select, one byte of write data, the interrupt-enable flag and a 2-bit segment code. The block then runs a bus cycle on the pins. The cycle has the fixed phases T1, T2, T3 and T4, and the sequencer adds wait phases between T2 and T3 while the external `ready_in` line is low.

In T1 the shared pins and the upper pins carry the address, and the latch strobe `ale` is raised so that outside logic can hold the address. After T1 the top four pins stop carrying address and carry status instead. The sequencer drives the read or write strobe and the data buffer enable through T2, any wait phases and T3. A read captures the byte on the shared pins at the end of T3. In T4 the sequencer drops every strobe and pulses `done`. A new request can be taken in T4, which lets cycles run back to back with no idle clock between them.

The shared pins use the usual split form for a pad ring: `ad_out`, an output enable `ad_oe`, and `ad_in`. When `ad_oe` is low the pins float.

Top module: `mbus_seq`

## Requirements
- R1: While `rst` is high, and on the first clock after it falls with no request present, the outputs are `ale`=0, `rd_n`=1, `wr_n`=1, `buf_en_n`=1, `ad_oe`=0, `done`=0 and `rd_data`=0, and `req_ready` is 1.
- R2: A request that is accepted at a clock edge makes the next cycle T1. T1 lasts one clock. In T1, `ale`=1, `ad_oe`=1, `ad_out`=addr[7:0], `a_hi`=addr[15:8] and `as_hi`=addr[19:16]. In every later phase of the same cycle, `ale` is 0.
- R3: From T2 through T4, `as_hi` carries status. Bit 3 is 0, bit 2 is the interrupt-enable flag, and bits 1:0 are the segment code. `a_hi` keeps addr[15:8] for the whole cycle.
- R4: In a read (`req_write`=0), `rd_n` is 0 in T2, in every wait phase and in T3. `wr_n` stays 1. `ad_oe` is 0 from T2 through T4. `dir_tx` is 0 for the whole cycle.
- R5: In a write (`req_write`=1), `wr_n` is 0 in T2, in every wait phase and in T3. `rd_n` stays 1. `ad_oe` is 1 and `ad_out` equals the write byte from T2 through T4. `dir_tx` is 1 for the whole cycle.
- R6: `io_sel` equals the request's I/O select (1 = I/O port, 0 = memory) from T1 through T4.
- R7: `buf_en_n` is 0 from T2 through T3, including wait phases. It is 1 in T1 and in T4.
- R8: `ready_in` is sampled at the end of T2 and at the end of each wait phase. Each low sample adds one more wait phase, in which every strobe and pin keeps its T2 value. A cycle with n low samples takes 4+n clocks from T1 to T4.
- R9: In a read, `rd_data` takes the value on `ad_in` at the clock edge that ends T3. The new value is visible in T4 and is held until the next read captures.
- R10: `done` is 1 for exactly the single clock of T4. `req_ready` is 1 only when the sequencer is idle or in T4. A request presented in T4 makes the next clock the T1 of the new cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core request strobe |
| req_ready | output | 1 | Sequencer can take a request this clock |
| req_addr | input | 20 | Cycle address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O port access, 0 = memory access |
| req_wdata | input | 8 | Write byte |
| req_ie | input | 1 | Interrupt-enable flag shown in the status bits |
| req_seg | input | 2 | Segment code shown in the status bits |
| ready_in | input | 1 | External ready; low requests wait phases |
| ad_in | input | 8 | Value seen on the shared address/data pins |
| ad_out | output | 8 | Value driven onto the shared pins |
| ad_oe | output | 1 | Shared pins driven when 1, floating when 0 |
| a_hi | output | 8 | Address-only pins, addr[15:8] |
| as_hi | output | 4 | addr[19:16] in T1, status afterwards |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| io_sel | output | 1 | I/O versus memory select |
| dir_tx | output | 1 | Data buffer direction, 1 = transmit |
| buf_en_n | output | 1 | Data buffer enable, active low |
| rd_data | output | 8 | Byte captured by the last read |
| done | output | 1 | One-clock pulse in T4 |

## Verification
A wrong phase register shows up at the pins within one clock. A skipped or repeated phase moves the fall of `rd_n` or `wr_n`, the switch of `as_hi` from address to status, or the `done` pulse, so each phase is checked at its own clock. A miscounted wait state makes `done` arrive early or late. The bench checks the exact clock of `done` after several patterns of `ready_in`. A capture made from the wrong phase returns a deliberately different byte. This is because the bench drives the expected byte onto `ad_in` only during T3 and a different value before and after it.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

  localparam int STAT_W = 4;

  typedef enum logic [2:0] {
    BS_IDLE,
    BS_T1,
    BS_T2,
    BS_TW,
    BS_T3,
    BS_T4
  } bus_st_e;

  typedef struct packed {
    logic       wr;
    logic       io;
    logic       ie;
    logic [1:0] seg;
  } cyc_attr_t;

  function automatic logic [STAT_W-1:0] status_nib(input cyc_attr_t a);
    return {1'b0, a.ie, a.seg};
  endfunction

  function automatic logic strobe_phase(input bus_st_e s);
    return (s == BS_T2) || (s == BS_TW) || (s == BS_T3);
  endfunction

endpackage

// File: rtl/mbus_fsm.sv
module mbus_fsm
  import mbus_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    req_valid,
  input  logic    ready_in,
  output bus_st_e st_q,
  output bus_st_e st_nxt,
  output logic    accept,
  output logic    req_ready
);

  assign req_ready = (st_q == BS_IDLE) || (st_q == BS_T4);
  assign accept    = req_valid && req_ready;

  always_comb begin
    st_nxt = st_q;
    unique case (st_q)
      BS_IDLE: st_nxt = accept ? BS_T1 : BS_IDLE;
      BS_T1:   st_nxt = BS_T2;
      BS_T2:   st_nxt = ready_in ? BS_T3 : BS_TW;
      BS_TW:   st_nxt = ready_in ? BS_T3 : BS_TW;
      BS_T3:   st_nxt = BS_T4;
      BS_T4:   st_nxt = accept ? BS_T1 : BS_IDLE;
      default: st_nxt = BS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= BS_IDLE;
    else     st_q <= st_nxt;
  end

endmodule

// File: rtl/mbus_req_reg.sv
module mbus_req_reg
  import mbus_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_wdata,
  input  cyc_attr_t         in_attr,
  output logic [ADDR_W-1:0] addr_nxt,
  output logic [DATA_W-1:0] wdata_nxt,
  output cyc_attr_t         attr_nxt,
  output cyc_attr_t         attr_q
);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  assign addr_nxt  = accept ? in_addr  : addr_q;
  assign wdata_nxt = accept ? in_wdata : wdata_q;
  assign attr_nxt  = accept ? in_attr  : attr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      wdata_q <= '0;
      attr_q  <= '0;
    end else begin
      addr_q  <= addr_nxt;
      wdata_q <= wdata_nxt;
      attr_q  <= attr_nxt;
    end
  end

endmodule

// File: rtl/mbus_pin_drv.sv
module mbus_pin_drv
  import mbus_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8,
  localparam int MID_W = ADDR_W - DATA_W - STAT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  bus_st_e           st_nxt,
  input  logic [ADDR_W-1:0] addr_nxt,
  input  logic [DATA_W-1:0] wdata_nxt,
  input  cyc_attr_t         attr_nxt,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  output logic [MID_W-1:0]  a_hi,
  output logic [STAT_W-1:0] as_hi,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n,
  output logic              io_sel,
  output logic              dir_tx,
  output logic              buf_en_n,
  output logic              done
);

  logic [DATA_W-1:0] ad_d;
  logic [STAT_W-1:0] as_d;
  logic              oe_d, ale_d, rd_d, wr_d, io_d, dir_d, buf_d, done_d;
  logic              in_cycle;

  assign in_cycle = (st_nxt != BS_IDLE);

  always_comb begin
    ad_d   = ad_out;
    as_d   = as_hi;
    io_d   = io_sel;
    dir_d  = dir_tx;
    oe_d   = 1'b0;
    ale_d  = 1'b0;
    rd_d   = 1'b1;
    wr_d   = 1'b1;
    buf_d  = 1'b1;
    done_d = 1'b0;
    unique case (st_nxt)
      BS_T1: begin
        ad_d  = addr_nxt[DATA_W-1:0];
        as_d  = addr_nxt[ADDR_W-1 -: STAT_W];
        oe_d  = 1'b1;
        ale_d = 1'b1;
        io_d  = attr_nxt.io;
        dir_d = attr_nxt.wr;
      end
      BS_T2, BS_TW, BS_T3: begin
        as_d  = status_nib(attr_nxt);
        rd_d  = attr_nxt.wr;
        wr_d  = !attr_nxt.wr;
        buf_d = 1'b0;
        oe_d  = attr_nxt.wr;
        if (attr_nxt.wr) ad_d = wdata_nxt;
      end
      BS_T4: begin
        as_d   = status_nib(attr_nxt);
        oe_d   = attr_nxt.wr;
        done_d = 1'b1;
        if (attr_nxt.wr) ad_d = wdata_nxt;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ad_out   <= '0;
      as_hi    <= '0;
      ad_oe    <= 1'b0;
      ale      <= 1'b0;
      rd_n     <= 1'b1;
      wr_n     <= 1'b1;
      io_sel   <= 1'b0;
      dir_tx   <= 1'b0;
      buf_en_n <= 1'b1;
      done     <= 1'b0;
    end else begin
      ad_out   <= ad_d;
      as_hi    <= as_d;
      ad_oe    <= oe_d;
      ale      <= ale_d;
      rd_n     <= rd_d;
      wr_n     <= wr_d;
      io_sel   <= io_d;
      dir_tx   <= dir_d;
      buf_en_n <= buf_d;
      done     <= done_d;
    end
  end

  generate
    if (MID_W > 0) begin : g_mid
      always_ff @(posedge clk) begin
        if (rst)           a_hi <= '0;
        else if (in_cycle) a_hi <= addr_nxt[DATA_W +: MID_W];
      end
    end
  endgenerate

endmodule

// File: rtl/mbus_rd_cap.sv
module mbus_rd_cap
  import mbus_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  bus_st_e           st_q,
  input  cyc_attr_t         attr_q,
  input  logic [DATA_W-1:0] ad_in,
  output logic [DATA_W-1:0] rd_data
);

  always_ff @(posedge clk) begin
    if (rst)                                rd_data <= '0;
    else if (st_q == BS_T3 && !attr_q.wr)   rd_data <= ad_in;
  end

endmodule

// File: rtl/mbus_seq.sv
module mbus_seq
  import mbus_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8,
  localparam int MID_W = ADDR_W - DATA_W - STAT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              req_io,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_ie,
  input  logic [1:0]        req_seg,
  input  logic              ready_in,
  input  logic [DATA_W-1:0] ad_in,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  output logic [MID_W-1:0]  a_hi,
  output logic [STAT_W-1:0] as_hi,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n,
  output logic              io_sel,
  output logic              dir_tx,
  output logic              buf_en_n,
  output logic [DATA_W-1:0] rd_data,
  output logic              done
);

  bus_st_e           st_q, st_nxt;
  logic              accept;
  logic [ADDR_W-1:0] addr_nxt;
  logic [DATA_W-1:0] wdata_nxt;
  cyc_attr_t         attr_in, attr_nxt, attr_q;

  assign attr_in = '{wr: req_write, io: req_io, ie: req_ie, seg: req_seg};

  mbus_fsm u_fsm (
    .clk(clk), .rst(rst), .req_valid(req_valid), .ready_in(ready_in),
    .st_q(st_q), .st_nxt(st_nxt), .accept(accept), .req_ready(req_ready)
  );

  mbus_req_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_req (
    .clk(clk), .rst(rst), .accept(accept),
    .in_addr(req_addr), .in_wdata(req_wdata), .in_attr(attr_in),
    .addr_nxt(addr_nxt), .wdata_nxt(wdata_nxt), .attr_nxt(attr_nxt),
    .attr_q(attr_q)
  );

  mbus_pin_drv #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk(clk), .rst(rst), .st_nxt(st_nxt), .addr_nxt(addr_nxt),
    .wdata_nxt(wdata_nxt), .attr_nxt(attr_nxt),
    .ad_out(ad_out), .ad_oe(ad_oe), .a_hi(a_hi), .as_hi(as_hi),
    .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .io_sel(io_sel),
    .dir_tx(dir_tx), .buf_en_n(buf_en_n), .done(done)
  );

  mbus_rd_cap #(.DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst(rst), .st_q(st_q), .attr_q(attr_q),
    .ad_in(ad_in), .rd_data(rd_data)
  );

endmodule

// File: rtl/mbus_seq_chk.sv
module mbus_seq_chk
  import mbus_pkg::*;
#(
  parameter int STW = 4
) (
  input logic           clk,
  input logic           rst,
  input bus_st_e        st_q,
  input logic           ready_in,
  input logic           ale,
  input logic           rd_n,
  input logic           wr_n,
  input logic           buf_en_n,
  input logic           ad_oe,
  input logic [STW-1:0] as_hi,
  input logic           done,
  input logic           req_ready
);

  a_r2_ale_single: assert property (@(posedge clk) disable iff (rst)
    ale |=> !ale);

  a_r4_no_dual_strobe: assert property (@(posedge clk) disable iff (rst)
    (rd_n || wr_n));

  a_r4_read_floats: assert property (@(posedge clk) disable iff (rst)
    !rd_n |-> !ad_oe);

  a_r5_write_drives: assert property (@(posedge clk) disable iff (rst)
    !wr_n |-> ad_oe);

  a_r7_buf_with_strobe: assert property (@(posedge clk) disable iff (rst)
    !buf_en_n |-> (!rd_n || !wr_n));

  a_r3_s6_low: assert property (@(posedge clk) disable iff (rst)
    (st_q == BS_T2 || st_q == BS_TW || st_q == BS_T3 || st_q == BS_T4)
      |-> !as_hi[STW-1]);

  a_r8_wait_hold: assert property (@(posedge clk) disable iff (rst)
    ((st_q == BS_T2 || st_q == BS_TW) && !ready_in)
      |=> (st_q == BS_TW) && $stable(rd_n) && $stable(wr_n) && $stable(buf_en_n));

  a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r10_done_ready: assert property (@(posedge clk) disable iff (rst)
    done |-> req_ready);

endmodule

bind mbus_seq mbus_seq_chk #(.STW(mbus_pkg::STAT_W)) u_chk (
  .clk(clk), .rst(rst), .st_q(st_q), .ready_in(ready_in), .ale(ale),
  .rd_n(rd_n), .wr_n(wr_n), .buf_en_n(buf_en_n), .ad_oe(ad_oe),
  .as_hi(as_hi), .done(done), .req_ready(req_ready)
);

// File: tb/sim_mbus_seq.sv
`timescale 1ns/1ps
module sim_mbus_seq;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [19:0] req_addr = '0;
  logic        req_write = 1'b0, req_io = 1'b0, req_ie = 1'b0;
  logic [7:0]  req_wdata = '0;
  logic [1:0]  req_seg = '0;
  logic        ready_in = 1'b1;
  logic [7:0]  ad_in = '0;
  logic [7:0]  ad_out, a_hi, rd_data;
  logic [3:0]  as_hi;
  logic        ad_oe, ale, rd_n, wr_n, io_sel, dir_tx, buf_en_n, done;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  mbus_seq u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_io(req_io),
    .req_wdata(req_wdata), .req_ie(req_ie), .req_seg(req_seg),
    .ready_in(ready_in), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
    .a_hi(a_hi), .as_hi(as_hi), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
    .io_sel(io_sel), .dir_tx(dir_tx), .buf_en_n(buf_en_n),
    .rd_data(rd_data), .done(done)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Strobe-phase checks shared by T2, Tw and T3
  task automatic chk_mid(input string ph, input logic [19:0] a, input logic wr,
                         input logic io, input logic [7:0] wd, input logic ie,
                         input logic [1:0] sg);
    chk({"R2 ale low ", ph}, ale, 0);
    chk({"R3 status ", ph}, as_hi, {1'b0, ie, sg});
    chk({"R3 a_hi ", ph}, a_hi, a[15:8]);
    chk({"R4 rd_n ", ph}, rd_n, wr);
    chk({"R5 wr_n ", ph}, wr_n, !wr);
    chk({"R4 R5 ad_oe ", ph}, ad_oe, wr);
    if (wr) chk({"R5 write data ", ph}, ad_out, wd);
    chk({"R6 io_sel ", ph}, io_sel, io);
    chk({"R4 R5 dir_tx ", ph}, dir_tx, wr);
    chk({"R7 buf_en_n ", ph}, buf_en_n, 0);
    chk({"R10 done low ", ph}, done, 0);
    chk({"R10 busy ", ph}, req_ready, 0);
  endtask

  // Presents a request at the current negedge, returns at the T4 negedge.
  task automatic do_cycle(input logic [19:0] a, input logic wr, input logic io,
                          input logic [7:0] wd, input logic ie, input logic [1:0] sg,
                          input int nwait, input logic [7:0] rv);
    chk("R10 ready before accept", req_ready, 1);
    req_valid = 1; req_addr = a; req_write = wr; req_io = io;
    req_wdata = wd; req_ie = ie; req_seg = sg;
    ad_in = ~rv;
    @(negedge clk);  // T1
    req_valid = 0; req_addr = ~a; req_wdata = ~wd; req_ie = ~ie; req_seg = ~sg;
    chk("R2 ale", ale, 1);
    chk("R2 ad_oe", ad_oe, 1);
    chk("R2 ad_out", ad_out, a[7:0]);
    chk("R2 a_hi", a_hi, a[15:8]);
    chk("R2 as_hi addr", as_hi, a[19:16]);
    chk("R7 buf off T1", buf_en_n, 1);
    chk("R6 io T1", io_sel, io);
    chk("R4 R5 dir T1", dir_tx, wr);
    chk("R10 busy T1", req_ready, 0);
    @(negedge clk);  // T2
    chk_mid("T2", a, wr, io, wd, ie, sg);
    ready_in = (nwait > 0) ? 1'b0 : 1'b1;
    for (int w = 0; w < nwait; w++) begin
      @(negedge clk);  // Tw
      chk_mid("R8 Tw", a, wr, io, wd, ie, sg);
      ready_in = (w + 1 < nwait) ? 1'b0 : 1'b1;
    end
    @(negedge clk);  // T3
    chk_mid("T3", a, wr, io, wd, ie, sg);
    ad_in = rv;
    @(negedge clk);  // T4
    ad_in = ~rv;
    chk("R8 R10 done in T4", done, 1);
    chk("R7 buf off T4", buf_en_n, 1);
    chk("R4 rd_n off T4", rd_n, 1);
    chk("R5 wr_n off T4", wr_n, 1);
    chk("R4 R5 ad_oe T4", ad_oe, wr);
    chk("R3 status T4", as_hi, {1'b0, ie, sg});
    chk("R6 io T4", io_sel, io);
    chk("R10 ready in T4", req_ready, 1);
    if (!wr) chk("R9 rd_data", rd_data, rv);
  endtask

  task automatic go_idle(input logic [7:0] keep);
    @(negedge clk);
    chk("R10 done cleared", done, 0);
    chk("R10 ready idle", req_ready, 1);
    chk("R1 idle strobes", {ale, rd_n, wr_n, buf_en_n, ad_oe}, 5'b01110);
    chk("R9 rd_data held", rd_data, keep);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1 reset strobes", {ale, rd_n, wr_n, buf_en_n, ad_oe, done}, 6'b011100);
    chk("R1 reset rd_data", rd_data, 0);
    rst = 0;
    @(negedge clk);
    chk("R1 after reset strobes", {ale, rd_n, wr_n, buf_en_n, ad_oe, done}, 6'b011100);
    chk("R1 after reset ready", req_ready, 1);
  endtask

  task automatic t_read_plain();
    do_cycle(20'hA5C3E, 0, 0, 8'h00, 1, 2'b10, 0, 8'h5A);
    go_idle(8'h5A);
  endtask

  task automatic t_write_plain();
    do_cycle(20'h3F012, 1, 0, 8'hC7, 0, 2'b01, 0, 8'h00);
    go_idle(8'h5A);
  endtask

  task automatic t_read_waits();
    do_cycle(20'h71234, 0, 1, 8'h00, 0, 2'b11, 3, 8'h96);
    go_idle(8'h96);
  endtask

  task automatic t_write_waits();
    do_cycle(20'hEDB98, 1, 1, 8'h3C, 1, 2'b00, 2, 8'h00);
    go_idle(8'h96);
  endtask

  task automatic t_back_to_back();
    do_cycle(20'h10F0F, 1, 0, 8'h81, 1, 2'b01, 0, 8'h00);
    do_cycle(20'h8E1C2, 0, 1, 8'h00, 0, 2'b10, 1, 8'h4B);
    do_cycle(20'h0000F, 0, 0, 8'h00, 1, 2'b11, 0, 8'hE1);
    go_idle(8'hE1);
  endtask

  initial begin
    t_reset();
    t_read_plain();
    t_write_plain();
    t_read_waits();
    t_write_waits();
    t_back_to_back();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule